// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the control and status word of a processor floating-point unit. Software loads it through a write port. Only the low twelve bits are kept, and the upper bits of the readout are always zero. Two of the kept bits select the rounding mode. The block presents that mode to the arithmetic datapath in two forms: a 2-bit code taken from the register, and a registered one-hot select that is loaded on each write. Another kept bit enables floating-point traps.

At the end of each arithmetic operation the datapath offers a report of five raw IEEE exception conditions. The block remaps these conditions onto fixed status bits of the register and ORs them in, so the status bits are sticky. Only a software write can clear them. When an accepted report carries at least one condition and the trap-enable bit is set, the block raises a registered trap request for one cycle.

The report channel has a valid signal and a ready signal, with these rules:
- `flg_ready` is low in any cycle that has a software write. A report offered in that cycle is discarded, not held over, because the write takes priority.
- In every other cycle the block accepts the report at once.
- Each report is used only in the cycle it is offered. Nothing from it carries into later reports.

Top module: `fpu_ctl_stat`

## Requirements
- R1: A synchronous reset with `rst_n` low clears the register to zero, and the readout is 0. After reset `rnd_mode` is 0, `rnd_sel_oh` is 4'b0001 and `trap_req` is 0.
- R2: A write with `sw_wr_en` high loads `sw_wr_data[11:0]` into the register at the next clock edge. `rd_data[31:12]` is always zero.
- R3: `rnd_mode` always equals register bits 2:1. The codes are: 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R4: `rnd_sel_oh` is loaded on a write with bit N set for rounding code N, where N is the new value of register bits 2:1. It stays one-hot and always agrees with `rnd_mode`.
- R5: The raw flags `flg_raw` are indexed [0] invalid, [1] overflow, [2] underflow, [3] divide-by-zero, [4] inexact. In an accepted report they set register bits 8, 3, 4, 11 and 6 respectively.
- R6: Status bits are sticky. An accepted report ORs its flags into the register and never clears any bit.
- R7: `trap_req` is high in the cycle after an accepted report that has a nonzero `flg_raw`, provided register bit 0 (trap enable) was set when the report was accepted.
- R8: `trap_req` is low in the cycle after any cycle with no accepted report, an all-zero report, or trap enable clear.
- R9: When a write and a report occur in the same cycle, `flg_ready` is low, the written value is loaded, the report's flags are dropped, and no trap follows.
- R10: When `flg_valid` is low, `flg_raw` has no effect on the register or on `trap_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Register readout, bits 31:12 zero |
| flg_valid | input | 1 | Exception report valid, one per operation |
| flg_ready | output | 1 | Report accepted this cycle (low during a write) |
| flg_raw | input | 5 | Raw IEEE flags: invalid, overflow, underflow, divide-by-zero, inexact |
| rnd_mode | output | 2 | Rounding-mode code |
| rnd_sel_oh | output | 4 | One-hot rounding select |
| trap_req | output | 1 | Registered one-cycle trap request |

## Verification
The assertions check these relations on every cycle:
- write loading, including write-over-report priority;
- stickiness of status bits and immunity to invalid reports;
- agreement between the one-hot select and the 2-bit code;
- trap timing against the accepted report and the enable bit.

Only the bench scenarios can show the rest. They confirm the exact bit each raw flag lands on and the decoding of every rounding code. They also cover back-to-back trapping reports, and the reset of a fully populated register.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
  localparam int RAW_FLAGS = 5;
  localparam int EN_BIT    = 0;
  localparam int RM_LSB    = 1;
  localparam int RM_W      = 2;
  localparam int RM_CODES  = 1 << RM_W;

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_PLUS    = 2'd2,
    RM_MINUS   = 2'd3
  } rmode_e;

  // raw flag index -> architected status bit position
  function automatic int stat_pos(input int idx);
    case (idx)
      0:       stat_pos = 8;   // invalid
      1:       stat_pos = 3;   // overflow
      2:       stat_pos = 4;   // underflow
      3:       stat_pos = 11;  // divide-by-zero
      default: stat_pos = 6;   // inexact
    endcase
  endfunction
endpackage

// File: rtl/fpcs_flag_map.sv
module fpcs_flag_map
  import fpcs_pkg::*;
#(
  parameter int KEEP_W = 12
) (
  input  logic [RAW_FLAGS-1:0] raw,
  output logic [KEEP_W-1:0]    stat
);
  logic [KEEP_W-1:0] lane [RAW_FLAGS];

  for (genvar g = 0; g < RAW_FLAGS; g++) begin : g_lane
    localparam int POS = stat_pos(g);
    always_comb begin
      lane[g]      = '0;
      lane[g][POS] = raw[g];
    end
  end

  always_comb begin
    stat = '0;
    for (int i = 0; i < RAW_FLAGS; i++) stat = stat | lane[i];
  end
endmodule

// File: rtl/fpcs_rmode_dec.sv
module fpcs_rmode_dec
  import fpcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RM_W-1:0]     code,
  output logic [RM_CODES-1:0] sel_oh
);
  for (genvar g = 0; g < RM_CODES; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)    sel_oh[g] <= (g == int'(RM_NEAREST));
      else if (load) sel_oh[g] <= (code == g[RM_W-1:0]);
    end
  end

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel_oh));
endmodule

// File: rtl/fpcs_trap_gen.sv
module fpcs_trap_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic any_flag,
  input  logic enable,
  output logic trap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= accept & any_flag & enable;
  end

  p_trap_needs_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !trap_q);
endmodule

// File: rtl/fpu_ctl_stat.sv
module fpu_ctl_stat
  import fpcs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int KEEP_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_wr_en,
  input  logic [DATA_W-1:0]    sw_wr_data,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 flg_valid,
  output logic                 flg_ready,
  input  logic [RAW_FLAGS-1:0] flg_raw,
  output logic [RM_W-1:0]      rnd_mode,
  output logic [RM_CODES-1:0]  rnd_sel_oh,
  output logic                 trap_req
);
  localparam int PAD_W = DATA_W - KEEP_W;

  logic [KEEP_W-1:0] csr_q;
  logic [KEEP_W-1:0] stat_bits;
  logic              accept;
  logic              unused_hi;

  assign unused_hi = ^sw_wr_data[DATA_W-1:KEEP_W];
  assign flg_ready = ~sw_wr_en;
  assign accept    = flg_valid & flg_ready;

  fpcs_flag_map #(.KEEP_W(KEEP_W)) u_map (
    .raw  (flg_raw),
    .stat (stat_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        csr_q <= '0;
    else if (sw_wr_en) csr_q <= sw_wr_data[KEEP_W-1:0];
    else if (accept)   csr_q <= csr_q | stat_bits;
  end

  fpcs_rmode_dec u_rm (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (sw_wr_en),
    .code   (sw_wr_data[RM_LSB +: RM_W]),
    .sel_oh (rnd_sel_oh)
  );

  fpcs_trap_gen u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .any_flag (|flg_raw),
    .enable   (csr_q[EN_BIT]),
    .trap_q   (trap_req)
  );

  assign rd_data  = {{PAD_W{1'b0}}, csr_q};
  assign rnd_mode = csr_q[RM_LSB +: RM_W];

  p_wr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> rd_data[KEEP_W-1:0] == $past(sw_wr_data[KEEP_W-1:0]));
  p_oh_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_sel_oh[rnd_mode] == 1'b1);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> (rd_data & $past(rd_data)) == $past(rd_data));
  p_trap_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_valid && !sw_wr_en && (|flg_raw) && rd_data[EN_BIT]) |=> trap_req);
  p_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[EN_BIT] || !(|flg_raw)) |=> !trap_req);
  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> !trap_req);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |-> !flg_ready);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en && !flg_valid) |=> $stable(rd_data) && !trap_req);
endmodule

// File: tb/tb_fpu_ctl_stat.sv
`timescale 1ns/1ps
module tb_fpu_ctl_stat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] rd_data;
  logic        flg_valid = 1'b0;
  logic        flg_ready;
  logic [4:0]  flg_raw = '0;
  logic [1:0]  rnd_mode;
  logic [3:0]  rnd_sel_oh;
  logic        trap_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] rd;
    logic [1:0]  rm;
    logic [3:0]  oh;
    logic        trap;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [11:0] m_reg = '0;
  logic [3:0]  m_oh = 4'b0001;

  always #2 clk = ~clk;

  fpu_ctl_stat dut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .rd_data(rd_data), .flg_valid(flg_valid), .flg_ready(flg_ready),
    .flg_raw(flg_raw), .rnd_mode(rnd_mode), .rnd_sel_oh(rnd_sel_oh),
    .trap_req(trap_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] remap(input logic [4:0] f);
    logic [11:0] s = '0;
    if (f[0]) s[8]  = 1'b1;
    if (f[1]) s[3]  = 1'b1;
    if (f[2]) s[4]  = 1'b1;
    if (f[3]) s[11] = 1'b1;
    if (f[4]) s[6]  = 1'b1;
    return s;
  endfunction

  // driver: one cycle of stimulus, pushes expected post-edge outputs
  task automatic step(input string tag, input logic wr, input logic [31:0] d,
                      input logic v, input logic [4:0] f);
    exp_t e;
    logic t;
    @(negedge clk);
    sw_wr_en = wr; sw_wr_data = d; flg_valid = v; flg_raw = f;
    #0.5;
    chk({tag, " ready"}, {31'd0, flg_ready}, {31'd0, !wr});
    t = 1'b0;
    if (wr) begin
      m_reg = d[11:0];
      m_oh  = 4'b0001 << d[2:1];
    end else if (v) begin
      t = (f != 0) && m_reg[0];
      m_reg = m_reg | remap(f);
    end
    e.rd = {20'd0, m_reg}; e.rm = m_reg[2:1]; e.oh = m_oh; e.trap = t;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk({tg, " rd_data"}, rd_data, e.rd);
        chk({tg, " rnd_mode"}, {30'd0, rnd_mode}, {30'd0, e.rm});
        chk({tg, " rnd_sel_oh"}, {28'd0, rnd_sel_oh}, {28'd0, e.oh});
        chk({tg, " trap_req"}, {31'd0, trap_req}, {31'd0, e.trap});
      end
    end
  end

  task automatic check_reset(input string tag);
    @(negedge clk);
    chk({tag, " rd_data"}, rd_data, 32'd0);
    chk({tag, " rnd_mode"}, {30'd0, rnd_mode}, 32'd0);
    chk({tag, " rnd_sel_oh"}, {28'd0, rnd_sel_oh}, 32'd1);
    chk({tag, " trap_req"}, {31'd0, trap_req}, 32'd0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3/R4: upper bits dropped, mode 2 decoded
    step("R2 write keeps low bits", 1, 32'hFFFF_F5A5, 0, 5'd0);
    // R3/R4: every rounding code, traps off
    for (int m = 0; m < 4; m++) step("R3 R4 rounding code", 1, 32'(m << 1), 0, 5'd0);
    // R5/R8: each flag alone with enable clear
    step("R5 clear", 1, 32'd0, 0, 5'd0);
    for (int i = 0; i < 5; i++) begin
      step("R5 clear", 1, 32'd0, 0, 5'd0);
      step("R5 R8 single flag", 0, 32'd0, 1, 5'b1 << i);
    end
    // R6: sticky accumulation
    step("R6 accumulate a", 0, 32'd0, 1, 5'b00011);
    step("R6 accumulate b", 0, 32'd0, 1, 5'b10100);
    step("R6 empty report", 0, 32'd0, 1, 5'd0);
    step("R6 repeat", 0, 32'd0, 1, 5'b00001);
    // R7/R8: traps enabled
    step("R7 enable", 1, 32'h0000_0001, 0, 5'd0);
    step("R7 trap invalid", 0, 32'd0, 1, 5'b00001);
    step("R7 trap back-to-back", 0, 32'd0, 1, 5'b01000);
    step("R8 empty no trap", 0, 32'd0, 1, 5'd0);
    step("R8 idle no trap", 0, 32'd0, 0, 5'd0);
    // R9: write wins over a simultaneous report
    step("R9 write with report", 1, 32'h0000_0003, 1, 5'b11111);
    step("R9 after", 0, 32'd0, 0, 5'd0);
    // R10: flags without valid ignored
    step("R10 invalid report", 0, 32'd0, 0, 5'b11111);
    step("R10 after", 0, 32'd0, 0, 5'd0);
    // R1: reset of a populated register
    step("R1 populate", 0, 32'd0, 1, 5'b11111);
    step("R1 populate mode", 1, 32'h0000_0FFF, 0, 5'd0);
    @(negedge clk);
    sw_wr_en = 0; flg_valid = 0; flg_raw = 0;
    @(posedge clk); #1;
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    check_reset("R1 second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule